// File: doc/BRIEF.md
# Prioritised Interrupt Router

This block collects a set of external interrupt lines and steers them to a small number of processor contexts. Every source has a three-bit priority. Every context has three controls: a per-source enable mask, a priority threshold, and a single claim/complete register. A context raises its interrupt line when at least one source meets all of these conditions: it is pending, it is enabled for that context, and its priority is strictly higher than that context's threshold.

Software takes an interrupt by reading the context's claim register. The read returns the winning source ID and removes that source from the pending set. When the handler has finished, software writes the same ID back to the same register. That write reopens the source's gateway so that the source can request again.

Source 0 is reserved. Its priority reads as zero, and a claim result of 0 means that nothing is pending. Each source passes through a gateway. A parameter chooses the gateway kind: level-high for IDs below `EDGE_FROM`, rising-edge for IDs at or above it. Registers are reached through a simple 32-bit bus. A request is accepted in one cycle, and read data returns one cycle later.

Top module: `irq_router`

## Requirements
- R1: After reset, these all read 0: every priority, every enable mask, every threshold and the pending word. All `irq_o` bits are low.
- R2: The priority of source n is at byte address 4*n and holds 3 bits (wdata[2:0]). Bits 31..3 read as zero. The word for ID 0 always reads 0, and writes to it are dropped.
- R3: The enable mask of context c is the word at 0x2000 + 0x80*c. Bit n enables source n. Bit 0 always reads 0.
- R4: `irq_o[c]` is high exactly when some source meets three conditions: it is pending, it is enabled for c, and its priority is strictly greater than the threshold of c. A threshold of 7 blocks every source. A source with priority 0 never interrupts.
- R5: A read of 0x200004 + 0x1000*c returns the highest-priority eligible source for c, in the cycle after the request with `bus_rvalid` high. On equal priority the lowest ID wins. The read returns 0 when nothing is eligible.
- R6: A claim clears the claimed source's pending bit at the same clock edge that registers the read data. That source then raises no new request until it is completed.
- R7: Software completes a source by writing its ID, as the whole 32-bit value, to the claim address of a context. The completion takes effect only if that source is enabled for that context. Otherwise it is ignored.
- R8: The level gateway latches a request while its input is high and the gateway is open. The request stays pending even if the input drops before the claim. If the input is still high after completion, the source becomes pending again.
- R9: The edge gateway latches one request for each rising edge that arrives while the gateway is open. An input held high after completion does not request again. Edges that arrive while the source is already pending or claimed are dropped.
- R10: The word at 0x1000 shows the pending bits, with bit n for source n. Writes to it have no effect.
- R11: The threshold of context c is at 0x200000 + 0x1000*c and holds 3 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | NSRC (indices NSRC..1) | Interrupt source lines, bit n is source n |
| bus_req | input | 1 | Register access request, one cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| irq_o | output | NCTX | Interrupt line per context |

## Verification
The hardest situations to reach are those in which a gateway is closed while its input keeps moving. Examples are a level line that drops after its request was latched, and an edge line that toggles while its source is already claimed. Both are visible only through later pending reads and claims. The stimulus claims a source and then moves the input while the source is still in service. It then completes the source, or completes it from a context that does not have it enabled. After each step it reads the pending word to show whether the gateway reopened. Priority ties and the strict threshold comparison are set up by giving two sources equal priority, and by setting a threshold equal to a pending source's priority.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
    localparam int PRIO_W  = 3;
    localparam int DATA_W  = 32;
    // 4 KiB page numbers of the register regions
    localparam int PEND_PG = 1;      // 0x1000
    localparam int EN_PG   = 2;      // 0x2000
    localparam int CTL_PG  = 512;    // 0x200000
    localparam int EN_STRIDE_SH = 7; // 0x80 per context

    typedef logic [PRIO_W-1:0] prio_t;

    typedef enum logic [1:0] {
        GW_IDLE    = 2'd0,
        GW_PENDING = 2'd1,
        GW_SERVING = 2'd2
    } gw_state_e;

    typedef struct packed {
        logic rd;
        logic wr;
    } acc_t;
endpackage

// File: rtl/irq_gateway.sv
module irq_gateway
    import irq_router_pkg::*;
#(
    parameter bit IS_EDGE = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic src,
    input  logic claim,
    input  logic done,
    output logic pending
);
    gw_state_e state_q;
    logic      prev_q;
    logic      req;

    generate
        if (IS_EDGE) begin : g_edge
            assign req = src & ~prev_q;
        end else begin : g_level
            assign req = src;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= GW_IDLE;
            prev_q  <= 1'b0;
        end else begin
            prev_q <= src;
            unique case (state_q)
                GW_IDLE:    if (req)   state_q <= GW_PENDING;
                GW_PENDING: if (claim) state_q <= GW_SERVING;
                GW_SERVING: if (done)  state_q <= GW_IDLE;
                default:               state_q <= GW_IDLE;
            endcase
        end
    end

    assign pending = (state_q == GW_PENDING);
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_router_pkg::*;
#(
    parameter int NSRC = 15,
    localparam int ID_W = $clog2(NSRC + 1)
) (
    input  logic [NSRC:1]             pend,
    input  logic [NSRC:1]             en,
    input  logic [NSRC:1][PRIO_W-1:0] prio,
    input  prio_t                     thr,
    output logic [ID_W-1:0]           best_id,
    output logic                      irq
);
    prio_t best_p;

    // ascending scan, replace only on strictly higher priority: lowest ID wins ties
    always_comb begin
        best_id = '0;
        best_p  = '0;
        for (int i = 1; i <= NSRC; i++) begin
            if (pend[i] && en[i] && (prio[i] > thr) && (prio[i] > best_p)) begin
                best_id = ID_W'(i);
                best_p  = prio[i];
            end
        end
    end

    assign irq = (best_id != '0);
endmodule

// File: rtl/irq_router.sv
module irq_router
    import irq_router_pkg::*;
#(
    parameter int NSRC     = 15,
    parameter int NCTX     = 2,
    parameter int ADDR_W   = 24,
    parameter int EDGE_FROM = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NSRC:1]     src_i,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rvalid,
    output logic [NCTX-1:0]   irq_o
);
    localparam int ID_W = $clog2(NSRC + 1);
    localparam int PG_W = ADDR_W - 12;

    logic [NSRC:1][PRIO_W-1:0]  prio_q;
    logic [NCTX-1:0][NSRC:1]    en_q;
    logic [NCTX-1:0][PRIO_W-1:0] thr_q;
    logic [NSRC:1]              pend_vec, claim_vec, done_vec;
    logic [NCTX-1:0][ID_W-1:0]  best_id;

    // ---------------- address decode (one-hot selects) ----------------
    acc_t              acc;
    logic [PG_W-1:0]   page;
    logic [9:0]        widx;
    logic [NSRC:1]     sel_src;
    logic [NCTX-1:0]   sel_en, sel_thr, sel_clm;
    logic              sel_pend;
    logic [DATA_W-1:0] rd_mux;

    assign page    = bus_addr[ADDR_W-1:12];
    assign widx    = bus_addr[11:2];
    assign acc.rd  = bus_req & ~bus_we & (bus_addr[1:0] == 2'b00);
    assign acc.wr  = bus_req &  bus_we & (bus_addr[1:0] == 2'b00);
    assign sel_pend = (page == PG_W'(PEND_PG)) && (widx == 10'd0);

    generate
        for (genvar i = 1; i <= NSRC; i++) begin : g_src_sel
            assign sel_src[i] = (page == '0) && (widx == 10'(i));
        end
        for (genvar c = 0; c < NCTX; c++) begin : g_ctx_sel
            assign sel_en[c]  = (page == PG_W'(EN_PG)) &&
                                (bus_addr[11:EN_STRIDE_SH] == 5'(c)) &&
                                (bus_addr[EN_STRIDE_SH-1:2] == '0);
            assign sel_thr[c] = (page == PG_W'(CTL_PG + c)) && (widx == 10'd0);
            assign sel_clm[c] = (page == PG_W'(CTL_PG + c)) && (widx == 10'd1);
        end
    endgenerate

    // ---------------- register file ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            prio_q <= '0;
            en_q   <= '0;
            thr_q  <= '0;
        end else if (acc.wr) begin
            for (int i = 1; i <= NSRC; i++)
                if (sel_src[i]) prio_q[i] <= bus_wdata[PRIO_W-1:0];
            for (int c = 0; c < NCTX; c++) begin
                if (sel_en[c])  en_q[c]  <= bus_wdata[NSRC:1];
                if (sel_thr[c]) thr_q[c] <= bus_wdata[PRIO_W-1:0];
            end
        end
    end

    always_comb begin
        rd_mux = '0;
        for (int i = 1; i <= NSRC; i++)
            if (sel_src[i]) rd_mux = rd_mux | DATA_W'(prio_q[i]);
        if (sel_pend) rd_mux = rd_mux | DATA_W'({pend_vec, 1'b0});
        for (int c = 0; c < NCTX; c++) begin
            if (sel_en[c])  rd_mux = rd_mux | DATA_W'({en_q[c], 1'b0});
            if (sel_thr[c]) rd_mux = rd_mux | DATA_W'(thr_q[c]);
            if (sel_clm[c]) rd_mux = rd_mux | DATA_W'(best_id[c]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
        end else begin
            bus_rvalid <= bus_req & ~bus_we;
            bus_rdata  <= acc.rd ? rd_mux : '0;
        end
    end

    // ---------------- claim / complete pulses ----------------
    always_comb begin
        claim_vec = '0;
        done_vec  = '0;
        for (int c = 0; c < NCTX; c++) begin
            for (int i = 1; i <= NSRC; i++) begin
                if (acc.rd && sel_clm[c] && (best_id[c] == ID_W'(i)))
                    claim_vec[i] = 1'b1;
                if (acc.wr && sel_clm[c] && (bus_wdata == DATA_W'(i)) && en_q[c][i])
                    done_vec[i] = 1'b1;
            end
        end
    end

    // ---------------- gateways and per-context arbiters ----------------
    generate
        for (genvar i = 1; i <= NSRC; i++) begin : g_gw
            irq_gateway #(.IS_EDGE(i >= EDGE_FROM)) u_gw (
                .clk     (clk),
                .rst     (rst),
                .src     (src_i[i]),
                .claim   (claim_vec[i]),
                .done    (done_vec[i]),
                .pending (pend_vec[i])
            );
        end
        for (genvar c = 0; c < NCTX; c++) begin : g_arb
            irq_arbiter #(.NSRC(NSRC)) u_arb (
                .pend    (pend_vec),
                .en      (en_q[c]),
                .prio    (prio_q),
                .thr     (thr_q[c]),
                .best_id (best_id[c]),
                .irq     (irq_o[c])
            );
        end
    endgenerate
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
    parameter int NSRC = 15,
    parameter int NCTX = 2
) (
    input logic            clk,
    input logic            rst,
    input logic            bus_req,
    input logic            bus_we,
    input logic            bus_rvalid,
    input logic [NCTX-1:0] irq_o,
    input logic [NSRC:1]   pend_vec,
    input logic [NSRC:1]   claim_vec
);
    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_we) |=> bus_rvalid);                          // R5

    AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (rst)
        (irq_o != '0) |-> (pend_vec != '0));                           // R4

    AST_CLAIM_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(claim_vec));                                           // R6

    AST_CLAIM_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (claim_vec != '0) |=> ((pend_vec & $past(claim_vec)) == '0));   // R6

    generate
        for (genvar i = 1; i <= NSRC; i++) begin : g_fall
            AST_PEND_FALL_BY_CLAIM: assert property (@(posedge clk) disable iff (rst)
                $fell(pend_vec[i]) |-> $past(claim_vec[i]));            // R6
        end
    endgenerate
endmodule

bind irq_router irq_router_chk #(.NSRC(NSRC), .NCTX(NCTX)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_req    (bus_req),
    .bus_we     (bus_we),
    .bus_rvalid (bus_rvalid),
    .irq_o      (irq_o),
    .pend_vec   (pend_vec),
    .claim_vec  (claim_vec)
);

// File: tb/sim_irq_router.sv
module sim_irq_router;
    localparam int CLK_NS = 10;
    localparam int NSRC = 15;
    localparam int NCTX = 2;
    localparam int ADDR_W = 24;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NSRC:1]     src = '0;
    logic              bus_req = 1'b0;
    logic              bus_we = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              bus_rvalid;
    logic [NCTX-1:0]   irq_o;

    int total = 0;
    int bad   = 0;
    bit done_flag = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #(CLK_NS/2) clk = ~clk;

    irq_router #(.NSRC(NSRC), .NCTX(NCTX), .ADDR_W(ADDR_W), .EDGE_FROM(8)) u0 (
        .clk(clk), .rst(rst), .src_i(src),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
        .irq_o(irq_o)
    );

    function automatic logic [31:0] a_prio(int i); return 32'(i * 4); endfunction
    function automatic logic [31:0] a_en(int c);   return 32'h2000 + 32'(c * 'h80); endfunction
    function automatic logic [31:0] a_thr(int c);  return 32'h200000 + 32'(c * 'h1000); endfunction
    function automatic logic [31:0] a_clm(int c);  return a_thr(c) + 32'd4; endfunction
    localparam logic [31:0] A_PEND = 32'h1000;

    // monitor: pops expected read data as responses appear
    always @(negedge clk) begin
        if (bus_rvalid) begin
            total++;
            if (exp_q.size() == 0) begin
                bad++;
                $display("FAIL unexpected read response act=%h exp=none", bus_rdata);
            end else begin
                automatic logic [31:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                if (bus_rdata !== e) begin
                    bad++;
                    $display("FAIL %s act=%h exp=%h", t, bus_rdata, e);
                end
            end
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [31:0] a, logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a[ADDR_W-1:0]; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    // driver: push expectation, issue read
    task automatic rd(logic [31:0] a, logic [31:0] e, string t);
        @(negedge clk);
        exp_q.push_back(e);
        tag_q.push_back(t);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a[ADDR_W-1:0];
        @(negedge clk);
        bus_req = 1'b0;
    endtask

    task automatic chk(string t, logic [31:0] act, logic [31:0] e);
        total++;
        if (act !== e) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", t, act, e);
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog act=running exp=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 irq after reset", 32'(irq_o), 32'h0);
        rd(a_prio(3), 32'h0, "R1 prio reset");
        rd(a_en(0), 32'h0, "R1 enable reset");
        rd(a_thr(0), 32'h0, "R1 threshold reset");
        rd(A_PEND, 32'h0, "R1 pending reset");
        // R2 priority width and ID 0
        wr(a_prio(3), 32'hFF);
        rd(a_prio(3), 32'h7, "R2 prio 3 bits");
        wr(a_prio(0), 32'h5);
        rd(a_prio(0), 32'h0, "R2 id0 prio zero");
        // R3 enable map
        wr(a_en(0), 32'hFFFF);
        rd(a_en(0), 32'hFFFE, "R3 enable bit0 zero");
        // R10 pending word, R4 irq
        src[3] = 1'b1;
        idle(3);
        rd(A_PEND, 32'h8, "R10 pending bit3");
        wr(A_PEND, 32'h0);
        rd(A_PEND, 32'h8, "R10 pending write ignored");
        chk("R4 irq ctx0 eligible", 32'(irq_o[0]), 32'h1);
        chk("R4 irq ctx1 not enabled", 32'(irq_o[1]), 32'h0);
        // R11 threshold 7 blocks
        wr(a_thr(0), 32'h7);
        rd(a_thr(0), 32'h7, "R11 threshold readback");
        idle(1);
        chk("R4 threshold 7 blocks", 32'(irq_o[0]), 32'h0);
        wr(a_thr(0), 32'h0);
        // R5 tie, priority 0 never wins
        wr(a_prio(3), 32'h2);
        wr(a_prio(4), 32'h2);
        src[4] = 1'b1; src[5] = 1'b1;
        idle(3);
        rd(A_PEND, 32'h38, "R8 level pending 3,4,5");
        rd(a_clm(0), 32'd3, "R5 tie lowest id");
        rd(A_PEND, 32'h30, "R6 claim clears pending");
        rd(a_clm(0), 32'd4, "R5 second claim");
        rd(a_clm(0), 32'd0, "R5 prio0 source not claimable");
        idle(1);
        chk("R4 prio0 no irq", 32'(irq_o[0]), 32'h0);
        // R7 completion from a context without enable
        wr(a_clm(1), 32'd3);
        idle(3);
        rd(A_PEND, 32'h20, "R7 completion ignored when disabled");
        // R8 completion reopens level source still high
        wr(a_clm(0), 32'd3);
        idle(3);
        rd(A_PEND, 32'h28, "R8 level re-request after completion");
        rd(a_clm(0), 32'd3, "R8 reclaim");
        // R8 low line after completion: no request
        src[4] = 1'b0;
        wr(a_clm(0), 32'd4);
        idle(3);
        rd(A_PEND, 32'h20, "R8 low line no request");
        // R8 latched request survives input drop
        wr(a_prio(6), 32'h1);
        src[6] = 1'b1;
        idle(3);
        src[6] = 1'b0;
        idle(2);
        rd(A_PEND, 32'h60, "R8 latched after drop");
        rd(a_clm(0), 32'd6, "R8 claim latched source");
        // R9 edge gateway
        wr(a_prio(9), 32'h3);
        src[9] = 1'b1;
        idle(3);
        rd(A_PEND, 32'h220, "R9 rising edge latches");
        rd(a_clm(0), 32'd9, "R9 claim edge");
        wr(a_clm(0), 32'd9);
        idle(3);
        rd(A_PEND, 32'h20, "R9 held high no re-request");
        src[9] = 1'b0; idle(1); src[9] = 1'b1;
        idle(3);
        rd(A_PEND, 32'h220, "R9 new edge latches");
        rd(a_clm(0), 32'd9, "R9 claim second edge");
        src[9] = 1'b0; idle(1); src[9] = 1'b1;
        idle(2);
        wr(a_clm(0), 32'd9);
        idle(3);
        rd(A_PEND, 32'h20, "R9 edge while claimed dropped");
        src[9] = 1'b0;
        // R5 higher priority wins
        wr(a_prio(10), 32'h5);
        wr(a_prio(11), 32'h6);
        src[10] = 1'b1; src[11] = 1'b1;
        idle(1);
        src[10] = 1'b0; src[11] = 1'b0;
        idle(3);
        rd(a_clm(0), 32'd11, "R5 highest priority first");
        rd(a_clm(0), 32'd10, "R5 next priority");
        // R4 strict threshold on ctx1
        wr(a_en(1), 32'h1000);
        wr(a_prio(12), 32'h4);
        wr(a_thr(1), 32'h4);
        src[12] = 1'b1;
        idle(1);
        src[12] = 1'b0;
        idle(3);
        rd(A_PEND, 32'h1020, "R9 pulse latches");
        chk("R4 prio equal threshold blocked", 32'(irq_o[1]), 32'h0);
        wr(a_thr(1), 32'h3);
        idle(1);
        chk("R4 prio above threshold", 32'(irq_o[1]), 32'h1);
        rd(a_clm(1), 32'd12, "R5 ctx1 claim");
        idle(1);
        chk("R6 irq drops after claim", 32'(irq_o[1]), 32'h0);
        idle(4);
        if (exp_q.size() != 0) begin
            bad++;
            $display("FAIL R5 missing responses act=%0d exp=0", exp_q.size());
        end
        finish_run();
    end
endmodule